// File: doc/BRIEF.md
# Bitmap Power-of-Two Block Allocator

This block hands out regions of a 16384-byte buffer memory. The memory is cut into equal blocks, and a register bitmap of `MAP_WORDS` 32-bit words records which blocks are taken. An allocate request carries a byte size. The reply is either the byte offset of a region that fits the request, or the out-of-memory code 16384. A free request carries an offset and a size, and it releases the same blocks that the matching allocate marked. The memory itself is outside this block, and so is any record of which client owns which region.

The number of blocks marked is the size rounded up to whole blocks. The candidate start positions, however, are spaced by that block count rounded up to a power of two. Regions therefore stay naturally aligned, and no region ever straddles two map words. The search is first-fit: map words are tried in ascending order, and within a word the positions are tried in ascending order. One candidate is tested per clock cycle.

Both the request port and the response port use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so requests are back-pressured during a search and while a response is waiting. A response stays on `rsp_valid`/`rsp_data` without change until `rsp_ready` is high on a clock edge. Only after that edge is a new request accepted.

Top module: `blkmap_alloc`

## Requirements
- R1: After synchronous reset every block is free, `req_ready` is 1 and `rsp_valid` is 0, so the first allocation returns offset 0.
- R2: The block size is BLK = 16384/(32·MAP_WORDS). An allocation marks exactly ceil(size/BLK) blocks as used.
- R3: Candidate positions inside a word lie at multiples of the stride p, the smallest power of two (1..32) with size ≤ BLK·p. Every successful offset is therefore a multiple of BLK·p.
- R4: The search is first-fit. Words are tried in ascending order and, within a word, positions in ascending order. The first position whose ceil(size/BLK) bits are all clear is taken. The reply is (word·32 + position)·BLK.
- R5: An allocation of size 0, or of size above 32·BLK, returns 16384 with `rsp_valid` high one cycle after acceptance, and it changes no bit.
- R6: An allocation that finds no free run at any candidate returns 16384 and changes no bit.
- R7: A run never crosses a map word boundary. If the free bits at the end of one word are contiguous with the free bits at the start of the next, they are not combined into one run.
- R8: A free (`req_op`=1) clears ceil(size/BLK) bits, starting at bit (offset/BLK) mod 32 of word (offset/BLK)/32. Bits that would lie past bit 31 are dropped. A free whose word index is MAP_WORDS or more changes nothing. The response echoes the offset and is valid one cycle after acceptance.
- R9: One candidate is tested per cycle. If the hit is at the k-th candidate (counting from 1), `rsp_valid` rises k clock edges after the accepting edge. A search that fails rises after MAP_WORDS·32/p edges.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays stable and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_size | input | 16 | Byte size of the region |
| req_offset | input | 16 | Byte offset of the region to free (ignored for allocate) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 16 | Allocated offset, 16384 for out of memory, or the echoed free offset |

## Verification
A corrupted bitmap bit is not visible on any port by itself. It shows up on the next allocation whose first-fit search reaches that position: the reply is a different offset, or an out-of-memory code where a region should have been found. For this reason the bench tracks a reference bitmap and compares every reply against it over long mixed sequences of allocations and frees. A fault in the stride or in the candidate walker shows up within a single request, either as a misaligned offset or as a response that arrives on the wrong cycle, because the latency of each response gives away how many candidates were tested.

// File: rtl/blkmap_pkg.sv
package blkmap_pkg;
  localparam int MEM_BYTES = 16384;
  localparam int WORD_BITS = 32;
  localparam logic [15:0] OOM_CODE = 16'd16384;

  typedef enum logic {OP_ALLOC = 1'b0, OP_FREE = 1'b1} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_RESP} state_e;

  // n low-order ones; n saturates at a full word
  function automatic logic [31:0] ones_run(input logic [5:0] n);
    logic [32:0] t;
    t = (33'd1 << n) - 33'd1;
    return (n >= 6'd32) ? 32'hFFFF_FFFF : t[31:0];
  endfunction
endpackage

// File: rtl/blkmap_sizer.sv
module blkmap_sizer #(
  parameter int BLK_LOG = 8
) (
  input  logic [15:0] size,
  output logic        fits,
  output logic [5:0]  blocks,
  output logic [2:0]  stride_log
);
  localparam logic [16:0] ROUND = 17'((1 << BLK_LOG) - 1);

  logic [16:0] blocks_full;

  always_comb begin
    blocks_full = ({1'b0, size} + ROUND) >> BLK_LOG;
    fits        = (size != 16'd0) && (blocks_full <= 17'd32);
    blocks      = (blocks_full > 17'd32) ? 6'd32 : blocks_full[5:0];
    stride_log  = 3'd0;
    for (int i = 5; i >= 0; i--) begin
      if (blocks_full <= (17'd1 << i)) stride_log = 3'(i);
    end
  end
endmodule

// File: rtl/blkmap_bits.sv
module blkmap_bits #(
  parameter int MAP_WORDS = 2,
  parameter int WW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en,
  input  logic          upd_set,
  input  logic [WW-1:0] upd_word,
  input  logic [31:0]   upd_mask,
  input  logic [WW-1:0] rd_word,
  output logic [31:0]   rd_data
);
  logic [31:0] map_q [MAP_WORDS];

  for (genvar g = 0; g < MAP_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        map_q[g] <= '0;
      end else if (upd_en && (upd_word == WW'(g))) begin
        map_q[g] <= upd_set ? (map_q[g] | upd_mask) : (map_q[g] & ~upd_mask);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < MAP_WORDS; i++) begin
      if (rd_word == WW'(i)) rd_data = map_q[i];
    end
  end
endmodule

// File: rtl/blkmap_alloc.sv
module blkmap_alloc
  import blkmap_pkg::*;
#(
  parameter int MAP_WORDS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_op,
  input  logic [15:0] req_size,
  input  logic [15:0] req_offset,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data
);
  localparam int BLK     = MEM_BYTES / (WORD_BITS * MAP_WORDS);
  localparam int BLK_LOG = $clog2(BLK);
  localparam int WW      = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
  localparam logic [WW-1:0] LAST_WORD = WW'(MAP_WORDS - 1);

  state_e        state_q;
  logic [WW-1:0] word_q;
  logic [5:0]    pos_q;
  logic [5:0]    blocks_q;
  logic [2:0]    slog_q;
  logic [15:0]   rsp_q;

  logic        sz_fits;
  logic [5:0]  sz_blocks;
  logic [2:0]  sz_slog;

  blkmap_sizer #(.BLK_LOG(BLK_LOG)) u_sizer (
    .size      (req_size),
    .fits      (sz_fits),
    .blocks    (sz_blocks),
    .stride_log(sz_slog)
  );

  logic          accept;
  logic [15:0]   free_blk;
  logic [10:0]   free_word;
  logic          free_in_range;
  logic [31:0]   free_mask;
  logic [31:0]   cand_mask;
  logic [31:0]   cur_bits;
  logic          hit;
  logic [5:0]    pos_nx;
  logic          upd_en;
  logic          upd_set;
  logic [WW-1:0] upd_word;
  logic [31:0]   upd_mask;
  logic [63:0]   free_wide;
  logic [63:0]   cand_wide;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = rsp_q;
  assign accept    = req_valid && req_ready;

  always_comb begin
    free_blk      = req_offset >> BLK_LOG;
    free_word     = free_blk[15:5];
    free_in_range = free_word < 11'(MAP_WORDS);
    free_wide     = {32'd0, ones_run(sz_blocks)} << free_blk[4:0];
    free_mask     = free_wide[31:0];
    cand_wide     = {32'd0, ones_run(blocks_q)} << pos_q[4:0];
    cand_mask     = cand_wide[31:0];
    hit           = (cur_bits & cand_mask) == 32'd0;
    pos_nx        = pos_q + (6'd1 << slog_q);
  end

  always_comb begin
    upd_en   = 1'b0;
    upd_set  = 1'b0;
    upd_word = word_q;
    upd_mask = cand_mask;
    if (state_q == ST_IDLE) begin
      upd_en   = accept && (req_op == OP_FREE) && free_in_range;
      upd_word = free_word[WW-1:0];
      upd_mask = free_mask;
    end else if (state_q == ST_SEARCH) begin
      upd_en  = hit;
      upd_set = 1'b1;
    end
  end

  blkmap_bits #(.MAP_WORDS(MAP_WORDS), .WW(WW)) u_bits (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_set (upd_set),
    .upd_word(upd_word),
    .upd_mask(upd_mask),
    .rd_word (word_q),
    .rd_data (cur_bits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      pos_q    <= '0;
      blocks_q <= '0;
      slog_q   <= '0;
      rsp_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          word_q   <= '0;
          pos_q    <= '0;
          blocks_q <= sz_blocks;
          slog_q   <= sz_slog;
          if (req_op == OP_FREE) begin
            rsp_q   <= req_offset;
            state_q <= ST_RESP;
          end else if (!sz_fits) begin
            rsp_q   <= OOM_CODE;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (hit) begin
            rsp_q   <= 16'({word_q, pos_q[4:0]}) << BLK_LOG;
            state_q <= ST_RESP;
          end else if (pos_nx[5]) begin
            if (word_q == LAST_WORD) begin
              rsp_q   <= OOM_CODE;
              state_q <= ST_RESP;
            end else begin
              word_q <= word_q + 1'b1;
              pos_q  <= '0;
            end
          end else begin
            pos_q <= pos_nx;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blkmap_alloc_chk.sv
module blkmap_alloc_chk #(
  parameter int MAP_WORDS = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_op,
  input logic [15:0] req_size,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data
);
  localparam int BLK = 16384 / (32 * MAP_WORDS);

  logic        pend_alloc;
  logic [31:0] pend_align;

  function automatic logic [31:0] align_of(input logic [15:0] sz);
    logic [31:0] a;
    a = 32'(BLK) << 5;
    for (int i = 5; i >= 0; i--) begin
      if (32'(sz) <= (32'(BLK) << i)) a = 32'(BLK) << i;
    end
    return a;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_alloc <= 1'b0;
      pend_align <= 32'd1;
    end else if (req_valid && req_ready) begin
      pend_alloc <= (req_op == 1'b0);
      pend_align <= align_of(req_size);
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R10
  no_req_during_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && req_ready));

  // R5
  zero_size_oom_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_op && req_size == 16'd0
    |=> rsp_valid && rsp_data == 16'd16384);

  // R8
  free_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_op |=> rsp_valid);

  // R3
  offset_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && pend_alloc && rsp_data != 16'd16384
    |-> (32'(rsp_data) % pend_align) == 32'd0);

  // R4
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && pend_alloc |-> rsp_data <= 16'd16384);
endmodule

bind blkmap_alloc blkmap_alloc_chk #(.MAP_WORDS(MAP_WORDS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_op   (req_op),
  .req_size (req_size),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data)
);

// File: tb/blkmap_alloc_bench.sv
module blkmap_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAP_WORDS  = 2;
  localparam int BLK        = 16384 / (32 * MAP_WORDS);
  localparam int OOM        = 16384;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [15:0] req_size = '0;
  logic [15:0] req_offset = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] mdl [MAP_WORDS];
  int live_off [64];
  int live_sz  [64];
  int live_n = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  blkmap_alloc #(.MAP_WORDS(MAP_WORDS)) u_blkmap_alloc (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] runmask(input int n);
    logic [63:0] t;
    t = (64'd1 << n) - 64'd1;
    return t[31:0];
  endfunction

  function automatic void model_alloc(input int size, output int off, output int cand);
    int nb, p;
    nb = (size + BLK - 1) / BLK;
    off = OOM;
    cand = 1;
    if (size == 0 || nb > 32) return;
    p = 1;
    while (p < nb) p = p * 2;
    cand = 0;
    for (int w = 0; w < MAP_WORDS; w++) begin
      for (int pos = 0; pos < 32; pos += p) begin
        logic [31:0] m;
        cand++;
        m = runmask(nb) << pos;
        if ((mdl[w] & m) == 32'd0) begin
          mdl[w] = mdl[w] | m;
          off = (w * 32 + pos) * BLK;
          return;
        end
      end
    end
  endfunction

  function automatic void model_free(input int off, input int size);
    int b, nb;
    logic [63:0] m;
    b = off / BLK;
    nb = (size + BLK - 1) / BLK;
    if (nb > 32) nb = 32;
    if (b / 32 >= MAP_WORDS) return;
    m = {32'd0, runmask(nb)} << (b % 32);
    mdl[b / 32] = mdl[b / 32] & ~m[31:0];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    rsp_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < MAP_WORDS; w++) mdl[w] = '0;
    live_n = 0;
  endtask

  task automatic xact(input logic op, input int size, input int off, input int hold,
                      output int data, output int lat);
    @(negedge clk);
    chk("R10 req_ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    req_op = op;
    req_size = 16'(size);
    req_offset = 16'(off);
    @(posedge clk);
    #1 req_valid = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!rsp_valid && lat < 600);
    data = int'(rsp_data);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R10 rsp_valid held", int'(rsp_valid), 1);
      chk("R10 rsp_data stable", int'(rsp_data), data);
      chk("R10 req_ready low while pending", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic alloc_chk(input string tag, input int size, input int hold);
    int d, l, eo, ec;
    model_alloc(size, eo, ec);
    xact(1'b0, size, 0, hold, d, l);
    chk({tag, " offset"}, d, eo);
    chk("R9 latency", l, ec);
    if (d == eo && eo != OOM && live_n < 64) begin
      live_off[live_n] = eo;
      live_sz[live_n] = size;
      live_n++;
    end
  endtask

  task automatic free_chk(input string tag, input int off, input int size);
    int d, l;
    model_free(off, size);
    xact(1'b1, size, off, 0, d, l);
    chk({tag, " echo"}, d, off);
    chk("R8 free latency", l, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d, l;
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    chk("R1 reset req_ready", int'(req_ready), 1);
    chk("R1 reset rsp_valid", int'(rsp_valid), 0);
    alloc_chk("R1 first alloc at 0", 1, 0);

    // R5: zero size and oversize, bitmap untouched afterwards
    alloc_chk("R5 zero size", 0, 2);
    alloc_chk("R5 oversize", 32 * BLK + 1, 0);
    alloc_chk("R2 exact max size", 32 * BLK, 0);
    alloc_chk("R2 one byte after", 1, 0);

    // R6: fill every word, then request more
    do_reset();
    for (int w = 0; w < MAP_WORDS; w++) alloc_chk("R4 fill word", 32 * BLK, 0);
    alloc_chk("R6 full map", 1, 0);

    // R8: free partial run, out-of-range free ignored
    free_chk("R8 free middle", 4 * BLK, 3 * BLK);
    free_chk("R8 free out of range word", MAP_WORDS * 32 * BLK, 2 * BLK);
    alloc_chk("R8 reuse freed", 3 * BLK, 0);
    alloc_chk("R6 no space left", 2 * BLK, 0);

    // R7 and R3: free tail of word 0 is not joined with word 1
    do_reset();
    alloc_chk("R3 28 blocks", 28 * BLK, 0);
    alloc_chk("R7 8 blocks skip tail", 8 * BLK, 0);
    alloc_chk("R3 4 blocks in tail", 4 * BLK, 0);
    alloc_chk("R2 3 blocks stride 4", 2 * BLK + 1, 3);
    alloc_chk("R2 bit after 3-run", BLK, 0);

    // Constrained random mix
    do_reset();
    for (int it = 0; it < 400; it++) begin
      int pick, sz;
      pick = int'($urandom % 8);
      if (live_n > 0 && pick < 3) begin
        int k;
        k = int'($urandom % live_n);
        free_chk("R8 random free", live_off[k], live_sz[k]);
        live_off[k] = live_off[live_n - 1];
        live_sz[k] = live_sz[live_n - 1];
        live_n--;
      end else if (pick == 3) begin
        free_chk("R8 random stray free", int'($urandom % 65536), int'($urandom % 4096));
      end else begin
        case ($urandom % 4)
          0: sz = 1 + int'($urandom % BLK);
          1: sz = 1 + int'($urandom % (4 * BLK));
          2: sz = 1 + int'($urandom % (16 * BLK));
          default: sz = int'($urandom % (34 * BLK));
        endcase
        alloc_chk("R4 random alloc", sz, int'($urandom % 3));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule